// File: doc/BRIEF.md
# Serial-Configured Clock Fan-Out Enable Controller

This block sits beside an eighteen-way clock fan-out buffer and decides which copies of the reference clock reach their pins. A write-only two-wire serial slave, clocked by a faster system clock that oversamples the bus lines, takes a fixed ten-byte write frame. The frame holds the device address, two placeholder bytes, and seven data bytes. The first three data bytes carry one enable bit per output. The slave pulls the data line low to acknowledge each byte it takes. It never returns any data.

Each output is the reference clock ANDed with its enable bit, so a disabled output is driven low. A global output-enable pin works apart from the registers and the system clock. When that pin is low, every output's tri-state enable drops. Both serial lines pass through a two-flop synchronizer and a stability filter before any edge, start or stop is detected.

Top module: `clk_fanout_cfg`

## Requirements
- R1: After reset all eighteen enable bits are 1 and `sda_pull_o` is 0.
- R2: A frame is a start condition followed by ten bytes in this order: address, command, count, data 0 to data 6. When the address equals 8'hD2, the slave acknowledges each of the ten bytes. It does this by holding `sda_pull_o` high from the SCL fall after bit 8 until the SCL fall after the ninth clock.
- R3: When the address byte differs from 8'hD2, that byte and every later byte are left unacknowledged, and no enable changes until the next start condition.
- R4: Bits arrive most significant first. Data 0 bit k sets enable k, and data 1 bit k sets enable 8+k. Data 2 bit 7 sets enable 17 and data 2 bit 6 sets enable 16. A value of 1 enables the output.
- R5: The command and count bytes, data 2 bits 5..0, and data bytes 3 to 6 leave every enable unchanged.
- R6: `clk_o[i]` equals `ref_clk_i` when enable i is 1 and is 0 otherwise. Every bit of `clk_oe_o` equals `glob_oe_i`. Both paths are combinational.
- R7: An enable byte is committed only once all eight of its bits have been received. A stop or a repeated start inside a byte discards the partial byte. Bytes completed earlier in the same frame remain in force.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is not seen as an edge.
- R9: `sda_pull_o` rises only while filtered SCL is low, drops after a stop, and is never asserted for an eleventh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| glob_oe_i | input | 1 | Global output enable, low tri-states all outputs |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the data line |
| clk_o | output | 18 | Gated clock copies |
| clk_oe_o | output | 18 | Per-output tri-state enable |

## Verification
A bus line change takes `FILT_LEN`+3 system clocks to reach the filtered signal, which is six cycles by default. The acknowledge pull and any enable write follow one cycle after that. The bench drives the bus with a quarter bit of 16 system clocks and samples the acknowledge a full quarter after SCL rises, which is well past the due cycle. It reads the enables only after a frame's stop, through the gated outputs. The clock gating and tri-state paths have no register, so the bench checks them 1 ns after it changes `ref_clk_i` or `glob_oe_i`.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_e;
  localparam logic [7:0] DEV_ADDR_DEF = 8'hD2;
endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (&hist_q)       out_d = 1'b1;
    else if (~|hist_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import clkcfg_pkg::*;
#(
  parameter int          FRAME_BYTES = 10,
  parameter int          FIRST_DATA  = 3,
  parameter int          N_EN        = 3,
  parameter logic [7:0]  DEV_ADDR    = DEV_ADDR_DEF,
  localparam int         BYTE_W      = $clog2(FRAME_BYTES),
  localparam int         IDX_W       = (N_EN > 1) ? $clog2(N_EN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             pull_o,
  output logic             skip_o,
  output logic             stop_o
);
  rx_state_e         state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [7:0]        shift_q, shift_d;
  logic              pull_q, pull_d;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det, in_win;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign in_win    = (int'(byte_q) >= FIRST_DATA) && (int'(byte_q) < FIRST_DATA + N_EN);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    shift_d = shift_q;
    pull_d  = pull_q;
    wr_en_o = 1'b0;
    if (start_det) begin
      state_d = RX_BITS;
      bit_d   = '0;
      byte_d  = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = RX_IDLE;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        RX_BITS: begin
          if (scl_rise && bit_q < 4'd8) begin
            shift_d = {shift_q[6:0], sda_f};
            bit_d   = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (byte_q == '0 && shift_q != DEV_ADDR) begin
              state_d = RX_SKIP;
            end else begin
              state_d = RX_ACK;
              pull_d  = 1'b1;
              bit_d   = '0;
              wr_en_o = in_win;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            if (byte_q == BYTE_W'(FRAME_BYTES - 1)) begin
              state_d = RX_SKIP;
            end else begin
              byte_d  = byte_q + 1'b1;
              state_d = RX_BITS;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end

  assign wr_idx_o  = IDX_W'(int'(byte_q) - FIRST_DATA);
  assign wr_data_o = shift_q;
  assign pull_o    = pull_q;
  assign skip_o    = (state_q == RX_SKIP);
  assign stop_o    = stop_det;
endmodule

// File: rtl/cfg_enable_regs.sv
module cfg_enable_regs #(
  parameter int  NUM_OUT = 18,
  localparam int N_EN    = (NUM_OUT + 7) / 8,
  localparam int IDX_W   = (N_EN > 1) ? $clog2(N_EN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  output logic [NUM_OUT-1:0] en_o
);
  logic [NUM_OUT-1:0] en_q, en_d;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    localparam int BYTE = i / 8;
    localparam int REM  = NUM_OUT - BYTE * 8;
    localparam int BITP = (REM >= 8) ? (i % 8) : (8 - REM + (i % 8));
    always_comb begin
      en_d[i] = en_q[i];
      if (wr_en_i && wr_idx_i == IDX_W'(BYTE)) en_d[i] = wr_data_i[BITP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_fanout_cfg.sv
module clk_fanout_cfg
  import clkcfg_pkg::*;
#(
  parameter int         NUM_OUT     = 18,
  parameter int         FILT_LEN    = 3,
  parameter int         FRAME_BYTES = 10,
  parameter int         FIRST_DATA  = 3,
  parameter logic [7:0] DEV_ADDR    = DEV_ADDR_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_i,
  input  logic               glob_oe_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  localparam int N_EN  = (NUM_OUT + 7) / 8;
  localparam int IDX_W = (N_EN > 1) ? $clog2(N_EN) : 1;

  logic [1:0]         raw, filt;
  logic               scl_f, sda_f;
  logic               wr_en, skip_st, stop_det;
  logic [IDX_W-1:0]   wr_idx;
  logic [7:0]         wr_data;
  logic [NUM_OUT-1:0] en_q;

  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    bus_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g]));
  end
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  cfg_serial_rx #(
    .FRAME_BYTES(FRAME_BYTES), .FIRST_DATA(FIRST_DATA),
    .N_EN(N_EN), .DEV_ADDR(DEV_ADDR)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .pull_o(sda_pull_o), .skip_o(skip_st), .stop_o(stop_det));

  cfg_enable_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .en_o(en_q));

  assign clk_o    = {NUM_OUT{ref_clk_i}} & en_q;
  assign clk_oe_o = {NUM_OUT{glob_oe_i}};
endmodule

// File: rtl/clk_fanout_cfg_chk.sv
module clk_fanout_cfg_chk #(
  parameter int NUM_OUT = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_f,
  input logic               wr_en,
  input logic               skip_st,
  input logic               stop_det,
  input logic               sda_pull_o,
  input logic               glob_oe_i,
  input logic [NUM_OUT-1:0] en_q,
  input logic [NUM_OUT-1:0] clk_oe_o
);
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
  // R9
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_f);
  // R3
  skip_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> !sda_pull_o);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_oe_i |-> (clk_oe_o == '0));
endmodule

bind clk_fanout_cfg clk_fanout_cfg_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .wr_en(wr_en),
  .skip_st(skip_st), .stop_det(stop_det), .sda_pull_o(sda_pull_o),
  .glob_oe_i(glob_oe_i), .en_q(en_q), .clk_oe_o(clk_oe_o));

// File: tb/test_clk_fanout_cfg.sv
`timescale 1ns/1ps
module test_clk_fanout_cfg;
  localparam time QT = 320ns;

  logic clk, rst_n, ref_clk, glob_oe, scl_drv, sda_drv;
  logic sda_pull;
  logic [17:0] clk_o, clk_oe;
  logic [17:0] exp_en;
  wire  sda_line = sda_drv & ~sda_pull;
  int   n_chk = 0, n_bad = 0;

  clk_fanout_cfg i_clk_fanout_cfg (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .glob_oe_i(glob_oe),
    .scl_i(scl_drv), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .clk_o(clk_o), .clk_oe_o(clk_oe));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_en(input string req);
    glob_oe = 1'b1; ref_clk = 1'b1; #1;
    check(req, 32'(clk_o), 32'(exp_en));
    ref_clk = 1'b0; #1;
    check({req, " R6 low"}, 32'(clk_o), 32'h0);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; #QT; scl_drv = 1'b1; #QT; sda_drv = 1'b0; #QT; scl_drv = 1'b0; #QT;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #QT; scl_drv = 1'b1; #QT; sda_drv = 1'b1; #QT;
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_drv = b;
    if (glitch) begin
      #(QT/2); scl_drv = 1'b1; #40; scl_drv = 1'b0; #(QT/2 - 40);
    end else #QT;
    scl_drv = 1'b1; #(2*QT); scl_drv = 1'b0; #QT;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 4);
    sda_drv = 1'b1; #QT; scl_drv = 1'b1; #QT;
    ack = !sda_line;
    #QT; scl_drv = 1'b0; #QT;
  endtask

  task automatic send_frame(input logic [7:0] f[10], output int acks);
    bit a;
    acks = 0;
    bus_start();
    for (int i = 0; i < 10; i++) begin
      send_byte(f[i], 1'b0, a);
      acks += int'(a);
    end
  endtask

  task automatic t_reset();
    check("R1 pull", 32'(sda_pull), 32'h0);
    exp_en = '1;
    check_en("R1 enables");
  endtask

  task automatic t_good_frame();
    logic [7:0] f[10] = '{8'hD2, 8'hFF, 8'h00, 8'hB1, 8'h6A, 8'h55,
                          8'h00, 8'hFF, 8'h12, 8'hC3};
    int acks; bit a;
    send_frame(f, acks);
    check("R2 ack count", 32'(acks), 32'd10);
    send_byte(8'h00, 1'b0, a);
    check("R9 no ack 11th", 32'(a), 32'h0);
    bus_stop();
    check("R9 pull after stop", 32'(sda_pull), 32'h0);
    exp_en = {2'b01, 8'h6A, 8'hB1};
    check_en("R4 R5 map");
  endtask

  task automatic t_bad_addr(input logic [7:0] ad);
    logic [7:0] f[10] = '{ad, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                          8'h00, 8'h00, 8'h00, 8'h00};
    int acks;
    send_frame(f, acks);
    bus_stop();
    check("R3 acks", 32'(acks), 32'd0);
    check_en("R3 unchanged");
  endtask

  task automatic t_oe();
    glob_oe = 1'b0; ref_clk = 1'b1; #1;
    check("R6 oe low", 32'(clk_oe), 32'h0);
    glob_oe = 1'b1; #1;
    check("R6 oe high", 32'(clk_oe), 32'h3FFFF);
    ref_clk = 1'b0;
  endtask

  task automatic t_partial_stop();
    bit a; int acks = 0;
    bus_start();
    send_byte(8'hD2, 1'b0, a); acks += int'(a);
    send_byte(8'h11, 1'b0, a); acks += int'(a);
    send_byte(8'h22, 1'b0, a); acks += int'(a);
    send_byte(8'h0F, 1'b0, a); acks += int'(a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    check("R7 acks before stop", 32'(acks), 32'd4);
    exp_en[7:0] = 8'h0F;
    check_en("R7 partial stop");
  endtask

  task automatic t_partial_restart();
    bit a;
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h3C, 1'b0, a);
    check("R7 ack after restart", 32'(a), 32'h1);
    bus_stop();
    exp_en[7:0] = 8'h3C;
    check_en("R7 restart");
  endtask

  task automatic t_glitch();
    bit a;
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'hAA, 1'b1, a);
    check("R8 ack with glitch", 32'(a), 32'h1);
    bus_stop();
    exp_en[7:0] = 8'hAA;
    check_en("R8 glitch ignored");
  endtask

  initial begin
    rst_n = 1'b0; ref_clk = 1'b0; glob_oe = 1'b1;
    scl_drv = 1'b1; sda_drv = 1'b1; exp_en = '1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good_frame();
    t_bad_addr(8'hD3);
    t_bad_addr(8'h4B);
    t_oe();
    t_partial_stop();
    t_partial_restart();
    t_glitch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule